// File: doc/BRIEF.md
# Dual-List Request Dispatch Scheduler

This block chooses which outstanding request slot goes to the execution engine next. Software uses two request lists. One holds transfers, which are storage commands and device-management requests in one shared slot space. The other holds task-management requests. Each list has its own doorbell vector, with one bit per slot. Software rings a slot by setting its bit. The bit stays high until the request is finished or aborted.

The scheduler records the order in which doorbell bits rise. Within each list it releases slots in that order, not in slot-index order. The task-management list has strict priority over the transfer list. The chosen slot is offered to the execution engine over a valid/ready handshake. An accepted slot is marked in flight and is never offered again until its doorbell bit has dropped and risen again. If a queued slot's bit drops before acceptance, the slot leaves the order without being dispatched.

Top module: `req_dispatch_sched`

## Requirements
- R1: While reset is asserted, and afterwards while no doorbell bit has risen, `disp_valid` is 0.
- R2: When a new offer is chosen, any queued task-management slot wins over every queued transfer slot. An offer uses `disp_list` = 1 for the task-management list and 0 for the transfer list.
- R3: Within one list, slots are offered in the order in which their doorbell bits rose. `disp_slot` carries the binary slot index, which is the bit position in that list's doorbell vector.
- R4: Bits of one list that rise in the same cycle are ordered by ascending slot index.
- R5: A bit that rises while earlier slots of its list are still queued or offered goes behind all of them, whatever its index.
- R6: While `disp_valid` is 1, `disp_ready` is 0 and the offered slot's doorbell bit stays set, `disp_valid`, `disp_list` and `disp_slot` do not change.
- R7: An accepted slot is not offered again while its doorbell bit stays set. After the bit clears and is set again, the slot is queued anew.
- R8: A queued slot whose doorbell bit clears before acceptance is dropped and is never offered.
- R9: If the offered slot's doorbell bit clears before acceptance, the offer is withdrawn at the next clock edge. The next eligible slot, if there is one, is offered in its place.
- R10: A slot whose doorbell bit is sampled high at clock edge k can be offered no earlier than edge k+1, with `disp_valid` high after edge k+1 when nothing else is offered. Accepting an offer lets the next slot appear at the same edge, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tm_doorbell | input | TM_SLOTS | Task-management doorbell, one bit per slot |
| xfer_doorbell | input | XFER_SLOTS | Transfer doorbell, one bit per slot |
| disp_ready | input | 1 | Execution engine accepts the current offer |
| disp_valid | output | 1 | An offer is presented |
| disp_list | output | 1 | List of the offer: 1 task-management, 0 transfer |
| disp_slot | output | max(clog2(TM_SLOTS), clog2(XFER_SLOTS)) | Slot index of the offer |

## Verification
A rising doorbell bit is registered at the first edge and can be offered at the second. An acceptance or a withdrawal replaces the offer at the very edge where it is seen. The bench therefore changes inputs only on falling edges. Its queue-based model steps on each rising edge, and the design's registered outputs are compared with the model on every falling edge. The directed checks count whole cycles from the falling edge that applied the stimulus. Latency and back-to-back hand-over are checked at exact cycle offsets, not by polling until a value shows up.

// File: rtl/dsp_sched_pkg.sv
// Shared types and helpers for the dual-list dispatch scheduler.
// Assumes: list identifiers fit in one bit; slot counts are at least 1.
package dsp_sched_pkg;

    typedef enum logic {
        LIST_XFER = 1'b0,
        LIST_TM   = 1'b1
    } list_id_e;

    // Index width for a vector of n slots (never below one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/onehot_to_index.sv
// Converts a one-hot (or all-zero) vector to the binary index of its set bit.
// Assumes: at most one bit of onehot is set; all-zero gives index 0.
module onehot_to_index #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] onehot,
    output logic [W-1:0] index
);

    // OR together the indices of all set bits.
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                index = index | W'(i);
            end
        end
    end

endmodule

// File: rtl/slot_order_tracker.sv
// Tracks one request list: detects rising doorbell bits, keeps their arrival
// order in an age matrix, marks accepted slots in flight and presents the
// oldest eligible slot.
// Assumes: grant is zero or one-hot and only names a slot that was presented.
//          older[j][i] = 1 means slot j rang before slot i (valid among queued).
module slot_order_tracker #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] doorbell,
    input  logic [SLOTS-1:0] grant,
    output logic             head_valid,
    output logic [IDX_W-1:0] head_idx
);

    logic [SLOTS-1:0] db_q;
    logic [SLOTS-1:0] queued;
    logic [SLOTS-1:0] inflight;
    logic [SLOTS-1:0] rise;
    logic [SLOTS-1:0] keep;
    logic [SLOTS-1:0] blocked;
    logic [SLOTS-1:0] head;
    logic [SLOTS-1:0] older [SLOTS];

    // New requests this cycle, and queued ones that survive this cycle.
    always_comb begin
        rise = doorbell & ~db_q;
        keep = queued & doorbell & ~grant;
    end

    // A surviving slot is blocked when any older surviving slot exists.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < SLOTS; j++) begin
                if (j != i && older[j][i] && keep[j]) begin
                    blocked[i] = 1'b1;
                end
            end
        end
        head = keep & ~blocked;
    end

    assign head_valid = |head;

    onehot_to_index #(
        .N (SLOTS),
        .W (IDX_W)
    ) u_head_enc (
        .onehot (head),
        .index  (head_idx)
    );

    // Doorbell history, queued set and in-flight set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q     <= '0;
            queued   <= '0;
            inflight <= '0;
        end else begin
            db_q     <= doorbell;
            queued   <= rise | keep;
            inflight <= doorbell & (inflight | grant);
        end
    end

    // Age matrix: a new slot is younger than all survivors; ties by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < SLOTS; j++) begin
                older[j] <= '0;
            end
        end else begin
            for (int j = 0; j < SLOTS; j++) begin
                for (int i = 0; i < SLOTS; i++) begin
                    if (rise[j]) begin
                        older[j][i] <= rise[i] && (j < i);
                    end else if (rise[i]) begin
                        older[j][i] <= keep[j];
                    end
                end
            end
        end
    end

    // The age matrix must never present two oldest slots.
    assert_single_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(head));

    // An in-flight slot is never granted a second time.
    assert_no_redispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & inflight) == '0);

    // Only a slot still held in the order may be granted.
    assert_grant_from_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~queued) == '0);

endmodule

// File: rtl/req_dispatch_sched.sv
// Dual-list dispatch scheduler: one order tracker per list, strict priority of
// the task-management list, and a registered offer held under valid/ready.
// Assumes: doorbell bits stay high until completion or abort; the offer is
//          withdrawn when its doorbell bit drops before acceptance.
module req_dispatch_sched #(
    parameter int unsigned TM_SLOTS   = 8,
    parameter int unsigned XFER_SLOTS = 32,
    localparam int unsigned TM_W   = dsp_sched_pkg::idx_width(TM_SLOTS),
    localparam int unsigned XF_W   = dsp_sched_pkg::idx_width(XFER_SLOTS),
    localparam int unsigned SLOT_W = (TM_W > XF_W) ? TM_W : XF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TM_SLOTS-1:0]   tm_doorbell,
    input  logic [XFER_SLOTS-1:0] xfer_doorbell,
    input  logic                  disp_ready,
    output logic                  disp_valid,
    output logic                  disp_list,
    output logic [SLOT_W-1:0]     disp_slot
);
    import dsp_sched_pkg::*;

    logic                  off_valid;
    list_id_e              off_list;
    logic [SLOT_W-1:0]     off_slot;
    logic                  accept;
    logic                  offered_db;
    logic                  withdraw;
    logic                  load;
    logic [TM_SLOTS-1:0]   tm_grant;
    logic [XFER_SLOTS-1:0] xf_grant;
    logic                  tm_hv;
    logic                  xf_hv;
    logic [TM_W-1:0]       tm_idx;
    logic [XF_W-1:0]       xf_idx;
    logic                  sel_valid;
    list_id_e              sel_list;
    logic [SLOT_W-1:0]     sel_slot;

    // Handshake outcome and doorbell state of the slot on offer.
    always_comb begin
        accept     = off_valid & disp_ready;
        offered_db = (off_list == LIST_TM) ? tm_doorbell[off_slot[TM_W-1:0]]
                                           : xfer_doorbell[off_slot[XF_W-1:0]];
        withdraw   = off_valid & ~offered_db;
        load       = ~off_valid | accept | withdraw;
    end

    // One-hot grant into the list that owned the accepted offer.
    always_comb begin
        tm_grant = '0;
        xf_grant = '0;
        if (accept && off_list == LIST_TM) begin
            tm_grant[off_slot[TM_W-1:0]] = 1'b1;
        end
        if (accept && off_list == LIST_XFER) begin
            xf_grant[off_slot[XF_W-1:0]] = 1'b1;
        end
    end

    slot_order_tracker #(
        .SLOTS (TM_SLOTS),
        .IDX_W (TM_W)
    ) u_tm_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .doorbell   (tm_doorbell),
        .grant      (tm_grant),
        .head_valid (tm_hv),
        .head_idx   (tm_idx)
    );

    slot_order_tracker #(
        .SLOTS (XFER_SLOTS),
        .IDX_W (XF_W)
    ) u_xfer_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .doorbell   (xfer_doorbell),
        .grant      (xf_grant),
        .head_valid (xf_hv),
        .head_idx   (xf_idx)
    );

    // Strict priority: task-management head first, transfer head otherwise.
    always_comb begin
        sel_valid = tm_hv | xf_hv;
        sel_list  = tm_hv ? LIST_TM : LIST_XFER;
        sel_slot  = tm_hv ? SLOT_W'(tm_idx) : SLOT_W'(xf_idx);
    end

    // Offer register: reloads only when empty, accepted or withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_valid <= 1'b0;
            off_list  <= LIST_XFER;
            off_slot  <= '0;
        end else if (load) begin
            off_valid <= sel_valid;
            off_list  <= sel_list;
            off_slot  <= sel_slot;
        end
    end

    assign disp_valid = off_valid;
    assign disp_list  = off_list;
    assign disp_slot  = off_slot;

    // A stalled offer with a live doorbell is held unchanged.
    assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (off_valid && !disp_ready && offered_db)
        |=> (disp_valid && $stable(disp_slot) && $stable(disp_list)));

    // A task-management slot wins whenever a new offer is chosen.
    assert_tm_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tm_hv) |=> (disp_valid && disp_list == LIST_TM));

    // An aborted offer does not survive the next edge.
    assert_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (off_valid && !offered_db)
        |=> !(disp_valid && disp_list == $past(disp_list)
              && disp_slot == $past(disp_slot)));

endmodule

// File: tb/req_dispatch_sched_tb.sv
// Bench: queue-based behavioural model stepped on rising edges, compared with
// the design on every falling edge, plus directed checks per requirement.
module req_dispatch_sched_tb;

    localparam int TMN = 8;
    localparam int XFN = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [TMN-1:0] tm_db;
    logic [XFN-1:0] xf_db;
    logic           ready;
    logic           disp_valid;
    logic           disp_list;
    logic [4:0]     disp_slot;

    int    vectors = 0;
    int    miscompares = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // model state
    int       tmq[$];
    int       xfq[$];
    bit [TMN-1:0] m_tm_prev;
    bit [XFN-1:0] m_xf_prev;
    bit       m_valid;
    bit       m_list;
    int       m_slot;

    always #10 clk = ~clk;

    req_dispatch_sched u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tm_doorbell   (tm_db),
        .xfer_doorbell (xf_db),
        .disp_ready    (ready),
        .disp_valid    (disp_valid),
        .disp_list     (disp_list),
        .disp_slot     (disp_slot)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        int  nq[$];
        bit  acc, odb, wd, sv, sl;
        int  ss;
        if (!rst_n) begin
            tmq.delete(); xfq.delete();
            m_tm_prev = '0; m_xf_prev = '0;
            m_valid = 1'b0; m_list = 1'b0; m_slot = 0;
        end else begin
            acc = m_valid && ready;
            odb = m_list ? tm_db[m_slot] : xf_db[m_slot];
            wd  = m_valid && !odb;
            nq.delete();
            foreach (tmq[k])
                if (tm_db[tmq[k]] && !(acc && m_list && m_slot == tmq[k])) nq.push_back(tmq[k]);
            tmq = nq;
            nq.delete();
            foreach (xfq[k])
                if (xf_db[xfq[k]] && !(acc && !m_list && m_slot == xfq[k])) nq.push_back(xfq[k]);
            xfq = nq;
            sv = 1'b0; sl = 1'b0; ss = 0;
            if (tmq.size() > 0) begin sv = 1'b1; sl = 1'b1; ss = tmq[0]; end
            else if (xfq.size() > 0) begin sv = 1'b1; sl = 1'b0; ss = xfq[0]; end
            for (int i = 0; i < TMN; i++) if (tm_db[i] && !m_tm_prev[i]) tmq.push_back(i);
            for (int i = 0; i < XFN; i++) if (xf_db[i] && !m_xf_prev[i]) xfq.push_back(i);
            m_tm_prev = tm_db;
            m_xf_prev = xf_db;
            if (!m_valid || acc || wd) begin
                m_valid = sv; m_list = sl; m_slot = ss;
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            vectors++;
            if (disp_valid !== m_valid ||
                (m_valid && (disp_list !== m_list || int'(disp_slot) != m_slot))) begin
                miscompares++;
                $display("FAIL %s model: got v=%0b l=%0b s=%0d exp v=%0b l=%0b s=%0d",
                         cur_req, disp_valid, disp_list, disp_slot, m_valid, m_list, m_slot);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Directed check of the visible offer.
    task automatic check_offer(input bit ev, input bit el, input int es, input string tag);
        vectors++;
        if (disp_valid !== ev || (ev && (disp_list !== el || int'(disp_slot) != es))) begin
            miscompares++;
            $display("FAIL %s directed: got v=%0b l=%0b s=%0d exp v=%0b l=%0b s=%0d",
                     tag, disp_valid, disp_list, disp_slot, ev, el, es);
        end
    endtask

    initial begin
        rst_n = 1'b0; ready = 1'b0; tm_db = '0; xf_db = '0;
        tick(3);
        cmp_en = 1'b1;
        check_offer(0, 0, 0, "R1");
        rst_n = 1'b1;
        tick(2);
        check_offer(0, 0, 0, "R1");

        // R10 latency and R3 arrival order
        cur_req = "R10";
        xf_db[5] = 1'b1;
        tick(1); check_offer(0, 0, 0, "R10");
        tick(1); check_offer(1, 0, 5, "R10");
        cur_req = "R3";
        xf_db[2] = 1'b1; tick(1);
        xf_db[9] = 1'b1; tick(3);
        check_offer(1, 0, 5, "R6");
        ready = 1'b1;
        tick(1); check_offer(1, 0, 2, "R3");
        tick(1); check_offer(1, 0, 9, "R3");
        tick(1); check_offer(0, 0, 0, "R10");
        // R7: no second offer while the bits stay set
        cur_req = "R7";
        tick(4); check_offer(0, 0, 0, "R7");
        xf_db[5] = 1'b0; xf_db[2] = 1'b0; xf_db[9] = 1'b0; ready = 1'b0;
        tick(1);
        xf_db[5] = 1'b1;
        tick(2); check_offer(1, 0, 5, "R7");
        ready = 1'b1; tick(1); check_offer(0, 0, 0, "R7");
        xf_db[5] = 1'b0; ready = 1'b0; tick(2);

        // R4: simultaneous rises by ascending index
        cur_req = "R4";
        xf_db[30] = 1'b1; xf_db[7] = 1'b1; xf_db[3] = 1'b1;
        tick(2); check_offer(1, 0, 3, "R4");
        ready = 1'b1;
        tick(1); check_offer(1, 0, 7, "R4");
        tick(1); check_offer(1, 0, 30, "R4");
        tick(1); check_offer(0, 0, 0, "R4");
        ready = 1'b0; xf_db = '0; tick(2);

        // R2: task-management beats older transfers
        cur_req = "R2";
        xf_db[1] = 1'b1; tick(1);
        xf_db[4] = 1'b1; tick(2);
        check_offer(1, 0, 1, "R2");
        tm_db[6] = 1'b1; tick(1);
        tm_db[2] = 1'b1; tick(2);
        check_offer(1, 0, 1, "R6");
        ready = 1'b1;
        tick(1); check_offer(1, 1, 6, "R2");
        tick(1); check_offer(1, 1, 2, "R2");
        tick(1); check_offer(1, 0, 4, "R2");
        tick(1); check_offer(0, 0, 0, "R2");
        ready = 1'b0; xf_db = '0; tm_db = '0; tick(2);

        // R5: later ring goes to the back regardless of index
        cur_req = "R5";
        xf_db[10] = 1'b1; tick(1);
        xf_db[11] = 1'b1; tick(2);
        xf_db[0] = 1'b1; tick(2);
        check_offer(1, 0, 10, "R5");
        ready = 1'b1;
        tick(1); check_offer(1, 0, 11, "R5");
        tick(1); check_offer(1, 0, 0, "R5");
        ready = 1'b0; tick(1);
        ready = 1'b1; tick(1);
        ready = 1'b0; xf_db = '0; tick(2);

        // R8: abort of a queued slot
        cur_req = "R8";
        xf_db[12] = 1'b1; xf_db[13] = 1'b1; xf_db[14] = 1'b1;
        tick(2); check_offer(1, 0, 12, "R8");
        xf_db[13] = 1'b0; tick(1);
        ready = 1'b1;
        tick(1); check_offer(1, 0, 14, "R8");
        tick(1); check_offer(0, 0, 0, "R8");
        ready = 1'b0; xf_db = '0; tick(2);

        // R9: abort of the offered slot
        cur_req = "R9";
        xf_db[20] = 1'b1; xf_db[21] = 1'b1;
        tick(2); check_offer(1, 0, 20, "R9");
        xf_db[20] = 1'b0;
        tick(1); check_offer(1, 0, 21, "R9");
        xf_db[21] = 1'b0;
        tick(1); check_offer(0, 0, 0, "R9");
        tick(2);

        // Mixed random traffic, compared against the model each cycle
        cur_req = "R6";
        for (int c = 0; c < 3000; c++) begin
            int s;
            ready = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 7) == 0) begin
                s = $urandom_range(0, TMN - 1);
                tm_db[s] = 1'b1;
            end
            if ($urandom_range(0, 2) == 0) begin
                s = $urandom_range(0, XFN - 1);
                xf_db[s] = 1'b1;
            end
            if ($urandom_range(0, 3) == 0) begin
                s = $urandom_range(0, XFN - 1);
                xf_db[s] = 1'b0;
            end
            if ($urandom_range(0, 5) == 0) begin
                s = $urandom_range(0, TMN - 1);
                tm_db[s] = 1'b0;
            end
            tick(1);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL %s watchdog: got running exp finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule